// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sits between a CPU bus master and the targets it reaches, whether memory or peripherals. It stretches each access by a programmed number of wait cycles. A write-only control byte holds two 3-bit wait fields. One field serves accesses to RAM and the other serves every other target. A region-select line from the address decoder chooses which field applies.

Each field is stored inverted: the number of waits is seven minus the field value. An all-ones register therefore means no waits, and that is the value the register takes at reset.

An access begins on the rising edge where the strobe is seen high while the block is idle. The wait count is captured at that edge. Once the count has run out, the block raises a one-cycle data acknowledge. If the master drops the strobe before the acknowledge, the access is abandoned without an acknowledge. A busy flag covers the whole access, including the acknowledge cycle.

Top module: `ws_wait_gen`

## Requirements
- R1: When `ram_sel_i` is 0, the wait count comes from control bits 6..4. Bits 2..0 have no effect on it.
- R2: When `ram_sel_i` is 1, the wait count comes from control bits 2..0. Bits 6..4 have no effect on it.
- R3: A selected field value F gives N = 7 − F waits. Call the start edge edge 0. `ack_o` is first high in the period after rising edge N, so the master samples it at edge N+1.
- R4: While reset is asserted, `ack_o` and `busy_o` are low. After reset the register holds all ones, so both regions give zero waits.
- R5: Control bits 7 and 3 are ignored. Writing them set or clear gives identical access timing.
- R6: The wait count is captured at the start edge. A register write that lands during an access leaves that access unchanged and applies from the next access.
- R7: `ack_o` is high for exactly one cycle. `busy_o` is high from the period after the start edge through the acknowledge period, and both outputs are low one edge later.
- R8: If the strobe is sampled low during the wait phase, the access is aborted. No acknowledge follows, and the block returns to idle.
- R9: A register write at the same edge as the start does not apply to the access that starts there. It applies to the next access.
- R10: An access starts only from idle. A strobe still high at the edge that ends the acknowledge does not start a new access; the next access starts one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_i | input | 1 | Access request from the bus master, held until acknowledge |
| ram_sel_i | input | 1 | 1 selects the RAM wait field, 0 selects the other field |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 8 | Control register write data |
| ack_o | output | 1 | One-cycle data acknowledge |
| busy_o | output | 1 | Access in progress |

## Verification
With N waits, the acknowledge is due in the period after the Nth rising edge following the start edge. It falls one edge later, and busy falls with it. All inputs change on the falling edge, and all outputs are sampled on falling edges. The bench counts rising edges from the start edge, so each result is read in the exact period the requirements name. For every field value in both regions, the bench compares the measured wait count with seven minus the field. For register writes it counts the edge that writes the register against the edge that starts the access, which separates the access already running from the next one.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } ws_state_e;

  localparam int unsigned REGION_CNT = 2;
  localparam int unsigned RGN_RAM    = 0;
  localparam int unsigned RGN_OTHER  = 1;

endpackage

// File: rtl/ws_rst_sync.sv
module ws_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ws_cfg_reg.sv
module ws_cfg_reg
  import ws_pkg::*;
#(
  parameter int unsigned FLD_W = 3,
  localparam int unsigned CFG_W = REGION_CNT * (FLD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [FLD_W-1:0] ram_fld_o,
  output logic [FLD_W-1:0] oth_fld_o
);

  logic [FLD_W-1:0]      fld_q [REGION_CNT];
  logic [REGION_CNT-1:0] unused_pad;

  for (genvar g = 0; g < REGION_CNT; g++) begin : g_fld
    localparam int unsigned LSB = g * (FLD_W + 1);

    logic [FLD_W-1:0] fld_d;

    always_comb begin
      fld_d = wdata_i[LSB +: FLD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q[g] <= '1;
      end else if (we_i) begin
        fld_q[g] <= fld_d;
      end
    end

    // pad bit above each field is not stored
    assign unused_pad[g] = wdata_i[LSB + FLD_W];
  end

  assign ram_fld_o = fld_q[RGN_RAM];
  assign oth_fld_o = fld_q[RGN_OTHER];

  // R5
  pad_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ram_fld_o == $past(wdata_i[FLD_W-1:0])) &&
             (oth_fld_o == $past(wdata_i[FLD_W+1 +: FLD_W])));

endmodule

// File: rtl/ws_sel.sv
module ws_sel #(
  parameter int unsigned FLD_W = 3
) (
  input  logic             ram_sel_i,
  input  logic [FLD_W-1:0] ram_fld_i,
  input  logic [FLD_W-1:0] oth_fld_i,
  output logic [FLD_W-1:0] waits_o
);

  localparam logic [FLD_W-1:0] FLD_MAX = '1;

  logic [FLD_W-1:0] fld_pick;

  always_comb begin
    fld_pick = ram_sel_i ? ram_fld_i : oth_fld_i;
    waits_o  = FLD_MAX - fld_pick;
  end

endmodule

// File: rtl/ws_seq.sv
module ws_seq
  import ws_pkg::*;
#(
  parameter int unsigned FLD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic [FLD_W-1:0] waits_i,
  output logic             ack_o,
  output logic             busy_o
);

  localparam logic [FLD_W-1:0] ONE = FLD_W'(1);

  ws_state_e        state_q, state_d;
  logic [FLD_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (strobe_i) begin
          if (waits_i == '0) begin
            state_d = ST_ACK;
          end else begin
            state_d = ST_WAIT;
            cnt_d   = waits_i - ONE;
            cnt_en  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!strobe_i) begin
          state_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          state_d = ST_ACK;
        end else begin
          cnt_d  = cnt_q - ONE;
          cnt_en = 1'b1;
        end
      end
      ST_ACK: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ack_o  = (state_q == ST_ACK);
  assign busy_o = (state_q != ST_IDLE);

  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !busy_o);

  // R8
  abort_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ack_o && !strobe_i) |=> (!busy_o && !ack_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !strobe_i) |=> !busy_o);

endmodule

// File: rtl/ws_wait_gen.sv
module ws_wait_gen
  import ws_pkg::*;
#(
  parameter int unsigned FLD_W = 3,
  localparam int unsigned CFG_W = REGION_CNT * (FLD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             ram_sel_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             ack_o,
  output logic             busy_o
);

  localparam logic [FLD_W-1:0] FLD_MAX = '1;

  logic             rst_q_n;
  logic [FLD_W-1:0] ram_fld, oth_fld, waits;

  ws_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_q_n)
  );

  ws_cfg_reg #(.FLD_W(FLD_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .ram_fld_o (ram_fld),
    .oth_fld_o (oth_fld)
  );

  ws_sel #(.FLD_W(FLD_W)) u_sel (
    .ram_sel_i (ram_sel_i),
    .ram_fld_i (ram_fld),
    .oth_fld_i (oth_fld),
    .waits_o   (waits)
  );

  ws_seq #(.FLD_W(FLD_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .strobe_i (strobe_i),
    .waits_i  (waits),
    .ack_o    (ack_o),
    .busy_o   (busy_o)
  );

  // Independent latency tracker for the acknowledge timing check
  logic [FLD_W-1:0] chk_age_q, chk_need_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      chk_age_q  <= '0;
      chk_need_q <= '0;
    end else if (!busy_o && strobe_i) begin
      chk_age_q  <= '0;
      chk_need_q <= FLD_MAX - (ram_sel_i ? ram_fld : oth_fld);
    end else if (busy_o) begin
      chk_age_q  <= chk_age_q + FLD_W'(1);
    end
  end

  // R3 R6
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ack_o |-> (chk_age_q == chk_need_q));

  // R4
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_q_n |-> (!ack_o && !busy_o));

endmodule

// File: tb/sim_ws_wait_gen.sv
`timescale 1ns/1ps
module sim_ws_wait_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe;
  logic       ram_sel;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       ack;
  logic       busy;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ws_wait_gen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (strobe),
    .ram_sel_i   (ram_sel),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .ack_o       (ack),
    .busy_o      (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // One access; wr_at = edge count (from start) at whose falling edge a write is driven, -1 for none
  task automatic run_access(input logic rgn, input int exp_n, input string req,
                            input int wr_at, input logic [7:0] wr_val);
    int k;
    int got;
    bit busy_ok;
    @(negedge clk);
    strobe  = 1'b1;
    ram_sel = rgn;
    if (wr_at == 0) begin
      cfg_we    = 1'b1;
      cfg_wdata = wr_val;
    end
    k       = 0;
    got     = -1;
    busy_ok = 1'b1;
    while (got < 0 && k < 12) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (k == wr_at + 1) cfg_we = 1'b0;
      if (!busy) busy_ok = 1'b0;
      if (ack) got = k - 1;
      else if (k == wr_at) begin
        cfg_we    = 1'b1;
        cfg_wdata = wr_val;
      end
    end
    strobe = 1'b0;
    cfg_we = 1'b0;
    check(got == exp_n, req, got, exp_n);
    check(busy_ok, "R7 busy held through access", int'(busy_ok), 1);
    @(posedge clk);
    @(negedge clk);
    check(!ack && !busy, "R7 ack single cycle and release", int'({ack, busy}), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit seen_ack;
    rst_n     = 1'b0;
    strobe    = 1'b0;
    ram_sel   = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    check(!ack && !busy, "R4 outputs low in reset", int'({ack, busy}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!ack && !busy, "R4 idle after reset", int'({ack, busy}), 0);

    // R4: reset value gives zero waits in both regions
    run_access(1'b1, 0, "R4 RAM zero waits after reset", -1, 8'h00);
    run_access(1'b0, 0, "R4 other zero waits after reset", -1, 8'h00);

    // R1 R2 R3: sweep all field values, the two fields differ
    for (int f = 0; f < 8; f++) begin
      logic [2:0] rf;
      logic [2:0] of;
      rf = 3'(f);
      of = 3'(7 - f);
      write_cfg({1'b0, of, 1'b0, rf});
      run_access(1'b1, 7 - f, "R2 R3 RAM field latency", -1, 8'h00);
      run_access(1'b0, 7 - (7 - f), "R1 R3 other field latency", -1, 8'h00);
    end

    // R5: pad bits set or clear give the same timing
    write_cfg(8'h52);
    run_access(1'b1, 5, "R5 RAM, pad bits clear", -1, 8'h00);
    run_access(1'b0, 2, "R5 other, pad bits clear", -1, 8'h00);
    write_cfg(8'hDA);
    run_access(1'b1, 5, "R5 RAM, pad bits set", -1, 8'h00);
    run_access(1'b0, 2, "R5 other, pad bits set", -1, 8'h00);

    // R6: write during the wait phase
    write_cfg(8'h72);
    run_access(1'b1, 5, "R6 write mid access ignored", 2, 8'h77);
    run_access(1'b1, 0, "R6 write applies to next access", -1, 8'h00);

    // R9: write on the start edge
    write_cfg(8'h72);
    run_access(1'b1, 5, "R9 write on start edge ignored", 0, 8'h7F);
    run_access(1'b1, 0, "R9 start-edge write applies next", -1, 8'h00);

    // R8: abort during wait
    write_cfg(8'h72);
    @(negedge clk);
    strobe  = 1'b1;
    ram_sel = 1'b1;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
    end
    strobe   = 1'b0;
    seen_ack = 1'b0;
    repeat (8) begin
      @(posedge clk);
      @(negedge clk);
      if (ack) seen_ack = 1'b1;
    end
    check(!seen_ack, "R8 no ack after abort", int'(seen_ack), 0);
    check(!busy, "R8 idle after abort", int'(busy), 0);
    run_access(1'b1, 5, "R8 access after abort", -1, 8'h00);

    // R10: strobe held through ack does not restart until idle
    write_cfg(8'h7F);
    @(negedge clk);
    strobe  = 1'b1;
    ram_sel = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(ack && busy, "R10 first ack", int'({ack, busy}), 3);
    @(posedge clk);
    @(negedge clk);
    check(!ack && !busy, "R10 no restart from ack state", int'({ack, busy}), 0);
    @(posedge clk);
    @(negedge clk);
    check(ack && busy, "R10 restart from idle", int'({ack, busy}), 3);
    strobe = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!ack && !busy, "R10 final idle", int'({ack, busy}), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule